// File: doc/BRIEF.md
# Address-Region Access Guard

This block screens every memory access the processor makes. It uses the current privilege level and a 16-bit mask that the block itself holds. The 64K-word address space is cut into sixteen equal 4K-word regions, and the top four address bits pick one of them. Each mask bit says whether user-mode code may touch its region. Supervisor-mode accesses are never blocked. Instruction fetches, data reads and data writes are all judged the same way.

One cycle after each valid access, the block answers with exactly one of two pulses:

- a grant pulse, meaning the access may proceed; or
- a fault pulse, meaning the access is blocked. The processor's exception logic picks the fault up from there.

The mask is a memory-mapped register at word address xFE12. It is written by a granted write to that address and read back by a granted read of it. Its address lies in region 15, so user code can change the mask only while region 15 is open to it. Reset clears the mask, which makes every region supervisor-only.

Top module: `region_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `acc_grant`, `acc_fault` and `csr_rdata` are 0. Reset leaves the mask at x0000, so any user-mode access is faulted and a supervisor read of xFE12 returns x0000.
- R2: The region of an access is `acc_addr[15:12]`. Mask bit i governs addresses i*x1000 through i*x1000+xFFF.
- R3: A valid user-mode access (`acc_user`=1) gets a grant if the mask bit of its region is 1 and a fault if that bit is 0.
- R4: A valid supervisor-mode access (`acc_user`=0) always gets a grant.
- R5: The kind codes are 00 fetch, 01 read and 10 write (11 is treated like a fetch). The region check is identical for every kind.
- R6: The result of an access sampled at a clock edge appears at the next edge as a one-cycle pulse. Exactly one of `acc_grant` or `acc_fault` is 1 after a valid access, and both are 0 after a cycle with `acc_valid`=0.
- R7: A granted write (kind 10) to xFE12 loads `acc_wdata` into the mask at that edge. The new value governs the following accesses.
- R8: A user-mode write to xFE12 is subject to mask bit 15. If that bit is 0, the write is faulted and the mask keeps its value.
- R9: For a granted read (kind 01) of xFE12, `csr_rdata` shows the mask one cycle later. After any other cycle it shows 0, and this includes a fault on xFE12 and a fetch of xFE12.
- R10: Writes to any address other than xFE12, and all non-write accesses, leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 16 | Word address of the access |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 treated as fetch |
| acc_wdata | input | 16 | Write data, used when writing xFE12 |
| acc_user | input | 1 | Privilege bit: 0 supervisor, 1 user |
| acc_grant | output | 1 | Pulse: the previous-cycle access is permitted |
| acc_fault | output | 1 | Pulse: the previous-cycle access is blocked |
| csr_rdata | output | 16 | Mask value after a granted read of xFE12, else 0 |

## Verification
Several kinds of user access are compared:

- Accesses on both sides of a region boundary (x0FFF against x1000, x2FFF against x3000) separate a correct index slice from an off-by-one or wrong-bit lookup.
- A sweep of one base address per region under a checkerboard mask exposes any swapped or stuck mask bit.
- The same addresses are repeated as fetch, read and write to show that the kind does not change the verdict.
- The same addresses are repeated in supervisor mode to show the bypass.

User writes to xFE12 are tried with region 15 both open and closed, each followed by a supervisor read-back. This separates a guarded mask write from an unguarded one. Idle cycles between accesses confirm that each verdict lasts a single cycle.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned NREG   = 1 << IDX_W;
    localparam int unsigned DATA_W = NREG;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_OTHER = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [NREG-1:0]   mask;
        logic              grant;
        logic              fault;
        logic [DATA_W-1:0] rdata;
    } guard_state_t;
endpackage

// File: rtl/region_lookup.sv
module region_lookup #(
    parameter int unsigned ADDR_W = region_guard_pkg::ADDR_W,
    parameter int unsigned IDX_W  = region_guard_pkg::IDX_W,
    localparam int unsigned NREG  = 1 << IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NREG-1:0]   mask,
    input  logic              user,
    output logic              permit
);
    logic [IDX_W-1:0] idx;
    logic [NREG-1:0]  sel;
    logic             open_bit;

    assign idx = addr[ADDR_W-1 -: IDX_W];

    // One-hot region select, one decoder per region
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = (idx == IDX_W'(g));
    end

    assign open_bit = |(sel & mask);
    assign permit   = !user || open_bit;
endmodule

// File: rtl/csr_match.sv
module csr_match #(
    parameter int unsigned ADDR_W = region_guard_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(16'hFE12)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    output logic              rd_hit,
    output logic              wr_hit
);
    import region_guard_pkg::*;
    logic at_csr;

    assign at_csr = (addr == CSR_ADDR);
    assign rd_hit = at_csr && (kind == ACC_READ);
    assign wr_hit = at_csr && (kind == ACC_WRITE);
endmodule

// File: rtl/region_guard.sv
module region_guard #(
    parameter int unsigned ADDR_W = region_guard_pkg::ADDR_W,
    parameter int unsigned IDX_W  = region_guard_pkg::IDX_W,
    parameter logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(16'hFE12),
    localparam int unsigned NREG  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [NREG-1:0]   acc_wdata,
    input  logic              acc_user,
    output logic              acc_grant,
    output logic              acc_fault,
    output logic [NREG-1:0]   csr_rdata
);
    import region_guard_pkg::*;

    guard_state_t st_d, st_q;
    logic         permit;
    logic         rd_hit;
    logic         wr_hit;
    logic [NREG-1:0] prot_mask;

    assign prot_mask = st_q.mask;

    region_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
        .addr   (acc_addr),
        .mask   (st_q.mask),
        .user   (acc_user),
        .permit (permit)
    );

    csr_match #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_match (
        .addr   (acc_addr),
        .kind   (acc_kind),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = acc_valid && permit;
        st_d.fault = acc_valid && !permit;
        st_d.rdata = '0;
        if (acc_valid && permit && rd_hit) begin
            st_d.rdata = st_q.mask;
        end
        if (acc_valid && permit && wr_hit) begin
            st_d.mask = acc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_grant = st_q.grant;
    assign acc_fault = st_q.fault;
    assign csr_rdata = st_q.rdata;
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 4,
    parameter logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(16'hFE12),
    localparam int unsigned NREG  = 1 << IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_kind,
    input logic              acc_user,
    input logic              acc_grant,
    input logic              acc_fault,
    input logic [NREG-1:0]   prot_mask
);
    // R6
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_grant && acc_fault));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!acc_grant && !acc_fault));

    // R4
    super_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_user) |=> acc_grant);

    // R3
    user_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_user && prot_mask[acc_addr[ADDR_W-1 -: IDX_W]]) |=> acc_grant);

    // R3
    user_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_user && !prot_mask[acc_addr[ADDR_W-1 -: IDX_W]]) |=> acc_fault);

    // R8
    guarded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_user && acc_kind == 2'b10 && acc_addr == CSR_ADDR
         && !prot_mask[NREG-1]) |=> (prot_mask == $past(prot_mask)));

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_kind == 2'b10 && acc_addr == CSR_ADDR) |=> $stable(prot_mask));
endmodule

bind region_guard region_guard_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CSR_ADDR(CSR_ADDR)
) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_kind  (acc_kind),
    .acc_user  (acc_user),
    .acc_grant (acc_grant),
    .acc_fault (acc_fault),
    .prot_mask (prot_mask)
);

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        acc_valid = 0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [15:0] acc_wdata = '0;
    logic        acc_user = 0;
    logic        acc_grant, acc_fault;
    logic [15:0] csr_rdata;

    int checks = 0;
    int failures = 0;
    logic [15:0] mask_m = 16'h0000;
    bit done = 0;

    typedef struct {
        logic        grant;
        logic        fault;
        logic [15:0] rdata;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    region_guard i_region_guard (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_wdata(acc_wdata), .acc_user(acc_user),
        .acc_grant(acc_grant), .acc_fault(acc_fault), .csr_rdata(csr_rdata)
    );

    localparam logic [1:0] K_FETCH = 2'b00, K_READ = 2'b01, K_WRITE = 2'b10;

    // Driver: present one access for one cycle and push its predicted verdict
    task automatic access(input logic v, input logic user, input logic [1:0] kind,
                          input logic [15:0] addr, input logic [15:0] wd, input string tag);
        exp_t e;
        logic ok;
        @(negedge clk);
        acc_valid = v; acc_user = user; acc_kind = kind; acc_addr = addr; acc_wdata = wd;
        ok = !user || mask_m[addr[15:12]];
        e.grant = v && ok;
        e.fault = v && !ok;
        e.rdata = (v && ok && kind == K_READ && addr == 16'hFE12) ? mask_m : 16'h0;
        e.tag   = tag;
        q.push_back(e);
        if (v && ok && kind == K_WRITE && addr == 16'hFE12) mask_m = wd;
    endtask

    task automatic idle(input string tag);
        access(1'b0, 1'b0, K_FETCH, 16'h0, 16'h0, tag);
    endtask

    // Monitor: compare outputs just after the edge that registers each result
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (acc_grant !== e.grant || acc_fault !== e.fault || csr_rdata !== e.rdata) begin
                failures++;
                $display("FAIL %s: got grant=%0b fault=%0b rdata=%h, expected grant=%0b fault=%0b rdata=%h",
                         e.tag, acc_grant, acc_fault, csr_rdata, e.grant, e.fault, e.rdata);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (acc_grant !== 1'b0 || acc_fault !== 1'b0 || csr_rdata !== 16'h0) begin
            failures++;
            $display("FAIL R1 reset outputs: got %0b %0b %h, expected 0 0 0000",
                     acc_grant, acc_fault, csr_rdata);
        end
        @(negedge clk); rst_n = 1;

        // R1: cleared mask blocks user, supervisor reads zero
        access(1, 1, K_FETCH, 16'h3000, 0, "R1 user fetch after reset");
        access(1, 0, K_READ,  16'hFE12, 0, "R1 R9 mask reads zero");
        // R7: supervisor loads the mask
        access(1, 0, K_WRITE, 16'hFE12, 16'h8009, "R7 supervisor mask write");
        access(1, 0, K_READ,  16'hFE12, 0, "R7 R9 readback");
        // R2 boundaries
        access(1, 1, K_READ,  16'h0FFF, 0, "R2 top of region 0");
        access(1, 1, K_READ,  16'h1000, 0, "R2 base of region 1");
        idle("R6 idle after fault");
        access(1, 1, K_READ,  16'h2FFF, 0, "R2 top of region 2");
        access(1, 1, K_READ,  16'h3000, 0, "R2 base of region 3");
        // R5 same verdict for every kind
        access(1, 1, K_FETCH, 16'h3ABC, 0, "R5 fetch open region");
        access(1, 1, K_WRITE, 16'h3123, 16'h1234, "R5 write open region");
        access(1, 1, K_WRITE, 16'h2000, 16'h1234, "R5 write closed region");
        access(1, 1, 2'b11,   16'h5000, 0, "R5 kind 11 closed region");
        // R4 supervisor bypass
        access(1, 0, K_READ,  16'h1000, 0, "R4 supervisor closed region");
        access(1, 0, K_WRITE, 16'h5555, 16'hFFFF, "R4 supervisor write");
        access(1, 0, K_FETCH, 16'hE000, 0, "R4 supervisor fetch");
        idle("R6 idle");
        idle("R6 idle");
        // R8 user write with region 15 open, then closed
        access(1, 1, K_WRITE, 16'hFE12, 16'h0002, "R8 user write region 15 open");
        access(1, 1, K_READ,  16'hFE12, 0, "R8 R9 user read now closed");
        access(1, 0, K_READ,  16'hFE12, 0, "R8 readback after user write");
        access(1, 1, K_WRITE, 16'hFE12, 16'hFFFF, "R8 user write region 15 closed");
        access(1, 0, K_READ,  16'hFE12, 0, "R8 mask unchanged");
        // R10 other writes do not touch mask
        access(1, 0, K_WRITE, 16'hFE10, 16'hFFFF, "R10 write neighbour address");
        access(1, 0, K_WRITE, 16'hFE13, 16'hFFFF, "R10 write neighbour address");
        access(1, 0, K_FETCH, 16'hFE12, 0, "R9 R10 fetch of mask address");
        access(1, 0, K_READ,  16'hFE12, 0, "R10 mask readback");
        // R3 sweep with checkerboard mask
        access(1, 0, K_WRITE, 16'hFE12, 16'hA5A5, "R7 load checkerboard");
        for (int i = 0; i < 16; i++) begin
            access(1, 1, K_READ, {i[3:0], 12'h7A5}, 0, "R3 region sweep");
        end
        access(1, 0, K_WRITE, 16'hFE12, 16'h5A5A, "R7 load inverse");
        for (int i = 0; i < 16; i++) begin
            access(1, 1, K_FETCH, {i[3:0], 12'h000}, 0, "R3 inverse sweep");
        end
        idle("R6 final idle");
        idle("R6 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule